// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block moves one PLL to a new output frequency on request. A caller gives a rate in MHz and a start pulse. The block rounds the rate to the closest setting in an internal table of supported PLL settings, and it builds the PLL control word from that setting's divider codes. It then issues register writes on a simple strobe port and waits a fixed lock interval. At the end of the interval it samples the PLL's lock and error status and reports a result code with a one-cycle done pulse.

A companion interface-clock divider must stay at divide-by-2 while the PLL runs above a rate threshold. The block orders that divider write around the PLL write for this reason. For a high target rate, divide-by-2 is written before the PLL changes. For a low target rate, divide-by-1 is written only once the PLL has locked without error. The analog PLL is outside the block and is seen only through its two status inputs.

Top module: `pll_reprog_seq`

## Requirements
- R1: While reset is held and right after it is released, busy_o, done_o, wr_ctrl_o and wr_div_o are 0 and result_o is 0 (success).
- R2: A start pulse is taken only while busy_o is low, and busy_o is high from the next cycle on. A start pulse that arrives while busy_o is high starts no new write. busy_o stays high through the single cycle in which done_o is high and falls in the next cycle.
- R3: The requested rate is replaced by the table entry with the smallest absolute difference in MHz, and on a tie the lower-rate (earlier) entry wins. The table runs from 100 MHz to 1600 MHz. Every entry satisfies f = 33.333 MHz · 2·(fb+1) / ((in+1)·2^out), for example 600 MHz = in 0, fb 17, out 1.
- R4: The PLL control word has power-down at bit 0 and bypass at bit 1, both always written as 0. The output-divider exponent sits in bits 3:2, the input-divider code in bits 8:4, the feedback-divider code in bits 15:9, and the band field from bit 20 upward, written as 0.
- R5: The lock interval is CLK_MHZ·LOCK_US cycles. Status is sampled exactly once, in the cycle LOCK_CYCLES+1 after the control write cycle. done_o follows one cycle later, or two cycles later when a divide-by-1 write is due.
- R6: result_o is 1 (timeout) when the lock input is low at the sample. It is 2 (bad configuration) when lock is high and error is high, and 0 (success) otherwise. The value changes only in the done cycle and is held until the next done cycle.
- R7: When the chosen table rate is above HI_RATE_MHZ, exactly one interface-divider write with data 1 (divide-by-2) is issued, in the cycle just before the control write. This happens whatever the later status.
- R8: When the chosen rate is at or below HI_RATE_MHZ, one interface-divider write with data 0 (divide-by-1) is issued in the cycle before done_o, and only on success. On a timeout or error no divider write occurs.
- R9: Each write cycle raises exactly one of wr_ctrl_o and wr_div_o. The address is CTRL_ADDR with wr_ctrl_o and DIV_ADDR with wr_div_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, taken while idle |
| req_rate_i | input | 12 | Requested PLL rate in MHz |
| lock_i | input | 1 | PLL lock status |
| err_i | input | 1 | PLL error status |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 0 success, 1 timeout, 2 bad configuration |
| wr_ctrl_o | output | 1 | Write strobe, PLL control register |
| wr_div_o | output | 1 | Write strobe, interface-divider register |
| wr_addr_o | output | 12 | Write address |
| wr_data_o | output | 32 | Write data |

## Verification
The results are due at fixed cycles. The divide-by-2 write comes one cycle after start is taken. The control write comes one cycle after start for a low rate and two cycles after for a high rate. Status is sampled LOCK_CYCLES+1 cycles after the control write, and done_o comes one cycle after that sample, or two cycles after on a successful low-rate change. The bench records the cycle number of every strobe and of done_o, and it compares the distances between them with these counts. The modelled PLL raises lock at a programmable distance from the control write, so that lock arriving exactly at the sample cycle passes and lock arriving one cycle later times out.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    localparam int RATE_W   = 12;
    localparam int ENTRIES  = 21;
    localparam int IN_W     = 5;
    localparam int FB_W     = 7;
    localparam int OUT_W    = 2;
    localparam int BAND_W   = 4;
    localparam int CW_W     = 32;
    localparam int OUT_LSB  = 2;
    localparam int IN_LSB   = 4;
    localparam int FB_LSB   = 9;
    localparam int BAND_LSB = 20;

    typedef struct packed {
        logic [RATE_W-1:0] mhz;
        logic [IN_W-1:0]   in_c;
        logic [FB_W-1:0]   fb_c;
        logic [OUT_W-1:0]  out_c;
    } pll_setting_t;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_TIMEOUT = 2'd1,
        RES_BADCFG  = 2'd2
    } seq_result_t;

    typedef enum logic [2:0] {
        S_IDLE, S_PRE_DIV, S_CTRL, S_WAIT, S_CHECK, S_POST_DIV, S_DONE
    } seq_state_t;

    // Supported settings, ascending rate; entries 13 and up follow a linear rule.
    function automatic pll_setting_t setting_at(int idx);
        pll_setting_t s;
        case (idx)
            0:  s = '{12'd100, 5'd0, 7'd11, 2'd3};
            1:  s = '{12'd125, 5'd0, 7'd14, 2'd3};
            2:  s = '{12'd133, 5'd0, 7'd15, 2'd3};
            3:  s = '{12'd150, 5'd0, 7'd17, 2'd3};
            4:  s = '{12'd200, 5'd1, 7'd47, 2'd3};
            5:  s = '{12'd233, 5'd1, 7'd27, 2'd2};
            6:  s = '{12'd300, 5'd1, 7'd35, 2'd2};
            7:  s = '{12'd333, 5'd1, 7'd39, 2'd2};
            8:  s = '{12'd400, 5'd1, 7'd47, 2'd2};
            9:  s = '{12'd500, 5'd0, 7'd14, 2'd1};
            10: s = '{12'd600, 5'd0, 7'd17, 2'd1};
            11: s = '{12'd700, 5'd0, 7'd20, 2'd1};
            12: s = '{12'd800, 5'd0, 7'd23, 2'd1};
            default: begin
                s.mhz   = RATE_W'(900 + 100 * (idx - 13));
                s.in_c  = IN_W'(1);
                s.fb_c  = FB_W'(26 + 3 * (idx - 13));
                s.out_c = '0;
            end
        endcase
        return s;
    endfunction

    function automatic logic [RATE_W-1:0] absdiff(logic [RATE_W-1:0] a, logic [RATE_W-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    // Power-down (bit 0), bypass (bit 1) and band stay cleared.
    function automatic logic [CW_W-1:0] pack_ctrl(pll_setting_t s);
        logic [CW_W-1:0] w;
        w = '0;
        w[0] = 1'b0;
        w[1] = 1'b0;
        w[OUT_LSB +: OUT_W]   = s.out_c;
        w[IN_LSB +: IN_W]     = s.in_c;
        w[FB_LSB +: FB_W]     = s.fb_c;
        w[BAND_LSB +: BAND_W] = '0;
        return w;
    endfunction

endpackage

// File: rtl/pll_rate_pick.sv
module pll_rate_pick
    import pll_seq_pkg::*;
(
    input  logic [RATE_W-1:0] req_i,
    output pll_setting_t      best_o
);
    always_comb begin
        pll_setting_t      cand;
        logic [RATE_W-1:0] best_d;
        logic [RATE_W-1:0] d;
        best_o = setting_at(0);
        best_d = absdiff(req_i, best_o.mhz);
        for (int i = 1; i < ENTRIES; i++) begin
            cand = setting_at(i);
            d    = absdiff(req_i, cand.mhz);
            // strict compare: a tie keeps the earlier entry
            if (d < best_d) begin
                best_o = cand;
                best_d = d;
            end
        end
    end
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
    parameter int unsigned CYCLES = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expired_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (!expired_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pll_seq_pkg::*;
#(
    parameter int unsigned CLK_MHZ     = 100,
    parameter int unsigned LOCK_US     = 100,
    parameter int unsigned HI_RATE_MHZ = 500,
    parameter int          ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h000,
    parameter logic [ADDR_W-1:0] DIV_ADDR  = 12'h100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [RATE_W-1:0] req_rate_i,
    input  logic              lock_i,
    input  logic              err_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        result_o,
    output logic              wr_ctrl_o,
    output logic              wr_div_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [CW_W-1:0]   wr_data_o
);
    localparam int unsigned LOCK_CYCLES = CLK_MHZ * LOCK_US;
    localparam logic [RATE_W-1:0] HI_THR = RATE_W'(HI_RATE_MHZ);
    localparam logic [CW_W-1:0] DIV_BY2 = CW_W'(1);
    localparam logic [CW_W-1:0] DIV_BY1 = '0;

    seq_state_t      state_q;
    seq_result_t     result_q;
    logic [CW_W-1:0] ctrl_q;
    logic            hi_q;
    pll_setting_t    pick;
    logic            pick_hi;
    logic            expired;

    pll_rate_pick u_pick (
        .req_i  (req_rate_i),
        .best_o (pick)
    );

    pll_lock_timer #(.CYCLES(LOCK_CYCLES)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run_i     (state_q == S_WAIT),
        .expired_o (expired)
    );

    assign pick_hi = (pick.mhz > HI_THR);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            result_q <= RES_OK;
            ctrl_q   <= '0;
            hi_q     <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: if (start_i) begin
                    ctrl_q  <= pack_ctrl(pick);
                    hi_q    <= pick_hi;
                    state_q <= pick_hi ? S_PRE_DIV : S_CTRL;
                end
                S_PRE_DIV: state_q <= S_CTRL;
                S_CTRL:    state_q <= S_WAIT;
                S_WAIT:    if (expired) state_q <= S_CHECK;
                S_CHECK: begin
                    if (!lock_i) begin
                        result_q <= RES_TIMEOUT;
                        state_q  <= S_DONE;
                    end else if (err_i) begin
                        result_q <= RES_BADCFG;
                        state_q  <= S_DONE;
                    end else if (hi_q) begin
                        result_q <= RES_OK;
                        state_q  <= S_DONE;
                    end else begin
                        state_q  <= S_POST_DIV;
                    end
                end
                S_POST_DIV: begin
                    result_q <= RES_OK;
                    state_q  <= S_DONE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        busy_o    = (state_q != S_IDLE);
        done_o    = (state_q == S_DONE);
        result_o  = result_q;
        wr_ctrl_o = (state_q == S_CTRL);
        wr_div_o  = (state_q == S_PRE_DIV) || (state_q == S_POST_DIV);
        wr_addr_o = wr_ctrl_o ? CTRL_ADDR : (wr_div_o ? DIV_ADDR : '0);
        case (state_q)
            S_CTRL:     wr_data_o = ctrl_q;
            S_PRE_DIV:  wr_data_o = DIV_BY2;
            S_POST_DIV: wr_data_o = DIV_BY1;
            default:    wr_data_o = '0;
        endcase
    end
endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk #(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h000,
    parameter logic [ADDR_W-1:0] DIV_ADDR  = 12'h100
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [1:0]        result_o,
    input logic              wr_ctrl_o,
    input logic              wr_div_o,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic [31:0]       wr_data_o
);
    // R2
    done_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> busy_o);

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!busy_o && !done_o));

    // R2
    start_take_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    // R9
    one_select_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_ctrl_o, wr_div_o}));

    // R9
    ctrl_addr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl_o |-> (wr_addr_o == CTRL_ADDR));

    // R9
    div_addr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_div_o |-> (wr_addr_o == DIV_ADDR));

    // R4
    ctrl_clean_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl_o |-> (wr_data_o[1:0] == 2'b00));

    // R7
    div2_first_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_div_o && wr_data_o == 32'd1) |=> wr_ctrl_o);

    // R8
    div1_after_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_div_o && wr_data_o == 32'd0) |=> (done_o && result_o == 2'd0));

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(result_o) |-> done_o);
endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR),
    .DIV_ADDR  (DIV_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .result_o  (result_o),
    .wr_ctrl_o (wr_ctrl_o),
    .wr_div_o  (wr_div_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o)
);

// File: tb/pll_reprog_seq_tb.sv
module pll_reprog_seq_tb;
    localparam int CLK_MHZ = 100;
    localparam int LOCK_US = 5;
    localparam int L       = CLK_MHZ * LOCK_US;
    localparam int HI      = 500;
    localparam logic [11:0] A_CTRL = 12'h000;
    localparam logic [11:0] A_DIV  = 12'h100;

    localparam int NT = 21;
    localparam int RATES [NT] = '{100,125,133,150,200,233,300,333,400,500,600,
                                  700,800,900,1000,1100,1200,1300,1400,1500,1600};
    localparam int INC [NT] = '{0,0,0,0,1,1,1,1,1,0,0,0,0,1,1,1,1,1,1,1,1};
    localparam int FBC [NT] = '{11,14,15,17,47,27,35,39,47,14,17,20,23,
                                26,29,32,35,38,41,44,47};
    localparam int OUTC[NT] = '{3,3,3,3,3,2,2,2,2,1,1,1,1,0,0,0,0,0,0,0,0};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [11:0] req = '0;
    logic        lock_in = 1'b0;
    logic        err_in = 1'b0;
    logic        busy, done, wr_ctrl, wr_div;
    logic [1:0]  result;
    logic [11:0] wr_addr;
    logic [31:0] wr_data;

    pll_reprog_seq #(.CLK_MHZ(CLK_MHZ), .LOCK_US(LOCK_US)) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .req_rate_i(req),
        .lock_i(lock_in), .err_i(err_in), .busy_o(busy), .done_o(done),
        .result_o(result), .wr_ctrl_o(wr_ctrl), .wr_div_o(wr_div),
        .wr_addr_o(wr_addr), .wr_data_o(wr_data)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    // monitor and PLL status model
    int n_ctrl, n_div, n_done, ctrl_cyc, div_cyc, done_cyc, k = 1000000;
    int lock_delay = 0;
    bit err_cfg = 0, done_busy;
    logic [31:0] ctrl_data, div_val;
    logic [11:0] ctrl_addr, div_addr;
    logic [1:0]  done_res;

    always @(negedge clk) begin
        if (wr_ctrl) begin
            n_ctrl++; ctrl_cyc = cyc; ctrl_data = wr_data; ctrl_addr = wr_addr; k = 0;
        end else if (k < 1000000) begin
            k++;
        end
        if (wr_div) begin
            n_div++; div_cyc = cyc; div_val = wr_data; div_addr = wr_addr;
        end
        if (done) begin
            n_done++; done_cyc = cyc; done_res = result; done_busy = busy;
        end
        lock_in = (k >= lock_delay);
        err_in  = err_cfg;
    end

    task automatic chk(bit ok, string rq, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic int tb_pick(int r);
        int b = 0;
        for (int i = 1; i < NT; i++) begin
            int da = (r > RATES[i]) ? r - RATES[i] : RATES[i] - r;
            int db = (r > RATES[b]) ? r - RATES[b] : RATES[b] - r;
            if (da < db) b = i;
        end
        return b;
    endfunction

    function automatic logic [31:0] tb_word(int i);
        return 32'((FBC[i] << 9) | (INC[i] << 4) | (OUTC[i] << 2));
    endfunction

    task automatic run_txn(int rate, int dly, bit er, bit poke);
        int idx = tb_pick(rate);
        bit hi = RATES[idx] > HI;
        bit ok = (dly <= L + 1) && !er;
        int exp_res = (dly > L + 1) ? 1 : (er ? 2 : 0);
        int s, guard, fb, inn, outp;
        longint fk;
        @(negedge clk);
        n_ctrl = 0; n_div = 0; n_done = 0;
        lock_delay = dly; err_cfg = er; req = 12'(rate); start = 1'b1; s = cyc;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", busy, 1);
        if (poke) begin
            repeat (20) @(negedge clk);
            req = 12'd1600; start = 1'b1;
            @(negedge clk);
            start = 1'b0; req = 12'(rate);
        end
        guard = 0;
        while (n_done == 0 && guard < L + 60) begin
            @(negedge clk); guard++;
        end
        chk(n_done == 1, "R2", "done seen", n_done, 1);
        chk(n_ctrl == 1, "R2", "control writes", n_ctrl, 1);
        // R3 nearest entry (ties resolved to earlier entry) and R4 field layout
        chk(ctrl_data == tb_word(idx), "R4", "control word", ctrl_data, tb_word(idx));
        fb = int'(ctrl_data[15:9]); inn = int'(ctrl_data[8:4]); outp = int'(ctrl_data[3:2]);
        fk = (longint'(33333) * 2 * (fb + 1)) / ((inn + 1) << outp);
        chk((fk > RATES[idx]*980) && (fk < RATES[idx]*1020), "R3", "decoded kHz", fk, RATES[idx]*1000);
        chk(ctrl_addr == A_CTRL, "R9", "control address", ctrl_addr, A_CTRL);
        chk(ctrl_cyc - s == (hi ? 2 : 1), "R7", "start to control write", ctrl_cyc - s, hi ? 2 : 1);
        chk(done_cyc - ctrl_cyc == L + 2 + ((!hi && ok) ? 1 : 0), "R5", "control write to done",
            done_cyc - ctrl_cyc, L + 2 + ((!hi && ok) ? 1 : 0));
        chk(done_res == 2'(exp_res), "R6", "result code", done_res, exp_res);
        chk(done_busy == 1'b1, "R2", "busy during done", done_busy, 1);
        if (hi) begin
            chk(n_div == 1 && div_val == 32'd1 && div_cyc == ctrl_cyc - 1, "R7",
                "divide-by-2 write before control", div_cyc, ctrl_cyc - 1);
            chk(div_addr == A_DIV, "R9", "divider address", div_addr, A_DIV);
        end else if (ok) begin
            chk(n_div == 1 && div_val == 32'd0 && div_cyc == done_cyc - 1, "R8",
                "divide-by-1 write after lock", div_cyc, done_cyc - 1);
        end else begin
            chk(n_div == 0, "R8", "no divider write on failure", n_div, 0);
        end
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && n_done == 1, "R2", "single done then idle", n_done, 1);
        chk(result == 2'(exp_res), "R6", "result held", result, exp_res);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1 during reset and after release
        chk(!busy && !done && !wr_ctrl && !wr_div, "R1", "outputs in reset", busy, 0);
        chk(result == 2'd0, "R1", "result in reset", result, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !wr_ctrl && !wr_div && result == 2'd0, "R1",
            "outputs after reset", busy, 0);

        run_txn(600, 5, 0, 0);        // high, success
        run_txn(300, 5, 0, 0);        // low, success
        run_txn(129, 5, 0, 0);        // R3 tie 125/133 -> 125
        run_txn(450, L + 2, 0, 0);    // R3 tie -> 400; lock one cycle late -> timeout
        run_txn(1650, 5, 1, 0);       // above table -> 1600, error
        run_txn(0, L + 1, 0, 0);      // below table -> 100, lock exactly at sample
        run_txn(550, L + 1, 1, 0);    // tie -> 500 (low), error keeps divider
        run_txn(501, 5, 0, 0);        // -> 500, threshold is inclusive on low side
        run_txn(1000, L + 2, 0, 0);   // high timeout, divide-by-2 already written
        run_txn(200, 5, 0, 1);        // start during busy is ignored
        for (int t = 0; t < 10; t++) begin
            int r = int'($urandom % 1800);
            int d;
            case ($urandom % 4)
                0: d = 5;
                1: d = L + 1;
                2: d = L + 2;
                default: d = L + 40;
            endcase
            run_txn(r, d, ($urandom % 4) == 0, 0);
        end
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule